// File: doc/BRIEF.md
# Service Packet Capture Buffer

This block sits after packet decoding and watches a stream of packets for the single reserved service and network identification packet. Each packet begins with a one-cycle header strobe carrying its address, type and data group type, followed by its payload as a stream of bytes. When the header names the reserved packet, the group type matches a host-selected value, and the buffer is not already holding a packet, the block stores the whole 90-byte (720-bit) payload. On the last byte it locks itself so later packets cannot overwrite what the host has not yet read.

The host reads the stored packet as 16-bit words through one read port, one word per read strobe. It can rewind the read pointer to read the packet again, or clear the buffer to release the lock and accept the next reserved packet. While the payload arrives the block runs a serial CRC over every bit, check bits included. The result is latched as a syndrome the host can read. It is zero when the packet arrived without error.

The payload input is a valid/ready stream whose ready output is held high at all times, so the upstream source never stalls. A byte that arrives while no capture is running is accepted and discarded. There is no back-pressure, because the packet source has no way to pause.

Top module: `svc_pkt_capture`

## Requirements
- R1: A header strobe starts a capture only when address equals 0x000, packet type equals 0xF8, group type equals `sel_group`, and `locked` is 0. The next 90 payload bytes are then stored.
- R2: If the header differs in any of these fields, its payload is discarded: `locked` stays 0 and the buffer contents are unchanged.
- R3: `locked` rises in the cycle after the 90th stored byte is accepted, and not after the 89th. It stays 1 until a clear.
- R4: While `locked` is 1, a matching packet changes neither the stored words nor `syndrome`.
- R5: `in_ready` is 1 in every cycle after reset, and bytes that arrive outside a capture are dropped.
- R6: `rd_data` shows word k as {byte 2k, byte 2k+1}, with the earlier byte in bits 15:8. Each `rd_strobe` advances to the next word, k running 0 to 44.
- R7: With the pointer past word 44, `rd_data` is 0. A further `rd_strobe` sets `eob`, which stays set and leaves the pointer where it is.
- R8: `rewind` returns the pointer to word 0 and clears `eob`. It leaves the stored data and `locked` as they are.
- R9: `clear_req` sets `locked` to 0 and zeroes the stored data, `syndrome`, the pointer and `eob`.
- R10: `syndrome` is the CRC with polynomial x^16+x^12+x^5+1 and initial value 0, taken most significant bit first over all 720 payload bits. It is latched when the capture completes, so it is 0 for a packet whose last two bytes are the CRC of the first 88.
- R11: After reset, `locked`, `eob`, `rd_data` and `syndrome` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header strobe; marks the start of a packet |
| hdr_addr | input | 10 | Packet address |
| hdr_type | input | 8 | Packet type byte |
| hdr_group | input | 4 | Data group type |
| sel_group | input | 4 | Host-selected data group type |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload ready, always high |
| in_data | input | 8 | Payload byte |
| rd_strobe | input | 1 | Advance the host read pointer by one word |
| rewind | input | 1 | Return the read pointer to word 0 |
| clear_req | input | 1 | Release the lock and clear the buffer |
| rd_data | output | 16 | Word at the read pointer |
| locked | output | 1 | Buffer holds a captured packet |
| eob | output | 1 | Sticky flag: a read went past the last word |
| syndrome | output | 16 | CRC syndrome of the captured packet |

## Verification
The hardest case to reach is a matching packet that arrives while the buffer is locked. It takes a complete capture of 90 bytes first, and the bench then has to show that the buffer contents and the syndrome did not change. The bench does this by capturing a packet whose first word is known, then sending a second matching packet with different bytes. It then compares the first word and the syndrome with their earlier values. A corrupted packet, whose syndrome the bench computes bit by bit, shows that the syndrome reflects the bits that arrived.

// File: rtl/svc_cap_pkg.sv
package svc_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE   = 2'd0,
    CAP_FILL   = 2'd1,
    CAP_LOCKED = 2'd2
  } cap_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/svc_hdr_match.sv
module svc_hdr_match #(
  parameter int ADDR_W = 10,
  parameter int TYPE_W = 8,
  parameter int GRP_W  = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '0,
  parameter logic [TYPE_W-1:0] SVC_TYPE = 8'hF8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TYPE_W-1:0] ptype,
  input  logic [GRP_W-1:0]  grp,
  input  logic [GRP_W-1:0]  sel,
  output logic              hit
);
  assign hit = (addr == SVC_ADDR) && (ptype == SVC_TYPE) && (grp == sel);
endmodule

// File: rtl/svc_crc16_byte.sv
module svc_crc16_byte
  import svc_cap_pkg::*;
(
  input  logic [15:0] crc_in,
  input  logic [7:0]  din,
  output logic [15:0] crc_out
);
  logic [15:0] stage [0:8];
  assign stage[0] = crc_in;

  for (genvar i = 0; i < 8; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][15] ^ din[7-i];
    assign stage[i+1] = {stage[i][14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end

  assign crc_out = stage[8];
endmodule

// File: rtl/svc_word_store.sv
module svc_word_store #(
  parameter int BYTES  = 90,
  parameter int WORD_W = 16,
  localparam int BPW    = WORD_W / 8,
  localparam int WORDS  = BYTES / BPW,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int PTR_W  = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_idx < PTR_W'(WORDS)) begin
      for (int b = 0; b < BPW; b++) begin
        rd_word[WORD_W-1-8*b -: 8] = mem[int'(rd_idx) * BPW + b];
      end
    end
  end
endmodule

// File: rtl/svc_pkt_capture.sv
module svc_pkt_capture
  import svc_cap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TYPE_W = 8,
  parameter int GRP_W  = 4,
  parameter int BYTES  = 90,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [GRP_W-1:0]  hdr_group,
  input  logic [GRP_W-1:0]  sel_group,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              rd_strobe,
  input  logic              rewind,
  input  logic              clear_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              locked,
  output logic              eob,
  output logic [15:0]       syndrome
);
  localparam int BPW   = WORD_W / 8;
  localparam int WORDS = BYTES / BPW;
  localparam int IDX_W = $clog2(BYTES);
  localparam int PTR_W = $clog2(WORDS + 1);

  cap_state_e       state;
  logic [IDX_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_ptr;
  logic [15:0]      crc_q, crc_nx;
  logic             hdr_hit, take_byte, last_byte;

  svc_hdr_match #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .GRP_W(GRP_W)
  ) u_match (
    .addr(hdr_addr), .ptype(hdr_type), .grp(hdr_group),
    .sel(sel_group), .hit(hdr_hit)
  );

  svc_crc16_byte u_crc (
    .crc_in(crc_q), .din(in_data), .crc_out(crc_nx)
  );

  assign take_byte = in_valid && (state == CAP_FILL) && !clear_req && !hdr_valid;
  assign last_byte = (wr_idx == IDX_W'(BYTES - 1));

  svc_word_store #(.BYTES(BYTES), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clear_req),
    .wr_en(take_byte), .wr_idx(wr_idx), .wr_byte(in_data),
    .rd_idx(rd_ptr), .rd_word(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CAP_IDLE;
      wr_idx   <= '0;
      crc_q    <= '0;
      syndrome <= '0;
    end else if (clear_req) begin
      state    <= CAP_IDLE;
      wr_idx   <= '0;
      crc_q    <= '0;
      syndrome <= '0;
    end else if (hdr_valid && state != CAP_LOCKED) begin
      state  <= hdr_hit ? CAP_FILL : CAP_IDLE;
      wr_idx <= '0;
      crc_q  <= '0;
    end else if (take_byte) begin
      crc_q <= crc_nx;
      if (last_byte) begin
        state    <= CAP_LOCKED;
        syndrome <= crc_nx;
        wr_idx   <= '0;
      end else begin
        wr_idx <= wr_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      eob    <= 1'b0;
    end else if (clear_req || rewind) begin
      rd_ptr <= '0;
      eob    <= 1'b0;
    end else if (rd_strobe) begin
      if (rd_ptr == PTR_W'(WORDS)) eob <= 1'b1;
      else rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign locked   = (state == CAP_LOCKED);
  assign in_ready = rst_n;
endmodule

// File: rtl/svc_pkt_capture_chk.sv
module svc_pkt_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear_req,
  input logic        rewind,
  input logic        in_valid,
  input logic        locked,
  input logic        eob,
  input logic [15:0] rd_data,
  input logic [15:0] syndrome
);
  // R3: lock persists until a clear
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear_req) |=> locked);

  // R3: lock only rises on an accepted payload byte
  a_r3_lock_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid));

  // R4 / R10: syndrome frozen while locked
  a_r4_syn_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear_req) |=> $stable(syndrome));

  // R9: clear releases the lock and zeroes the status
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (!locked && !eob && syndrome == 16'h0000));

  // R7: end flag is sticky until rewind or clear
  a_r7_eob_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eob && !rewind && !clear_req) |=> eob);

  // R7: past the end the read port returns zero
  a_r7_zero_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    eob |-> (rd_data == 16'h0000));

  // R8: rewind clears the end flag
  a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> !eob);
endmodule

bind svc_pkt_capture svc_pkt_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .rewind(rewind),
  .in_valid(in_valid), .locked(locked), .eob(eob),
  .rd_data(rd_data), .syndrome(syndrome)
);

// File: tb/tb_svc_pkt_capture.sv
module tb_svc_pkt_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [9:0]  hdr_addr = '0;
  logic [7:0]  hdr_type = '0;
  logic [3:0]  hdr_group = '0;
  logic [3:0]  sel_group = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        rd_strobe = 1'b0;
  logic        rewind = 1'b0;
  logic        clear_req = 1'b0;
  logic [15:0] rd_data;
  logic        locked;
  logic        eob;
  logic [15:0] syndrome;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] pkt [0:89];
  logic [7:0] held [0:89];

  always #4 clk = ~clk;

  svc_pkt_capture dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
    .hdr_type(hdr_type), .hdr_group(hdr_group), .sel_group(sel_group),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_strobe(rd_strobe), .rewind(rewind), .clear_req(clear_req),
    .rd_data(rd_data), .locked(locked), .eob(eob), .syndrome(syndrome)
  );

  // vector fields: addr[26:17] type[16:9] group[8:5] sel[4:1] expect_capture[0]
  localparam logic [26:0] VEC [0:7] = '{
    {10'h000, 8'hF8, 4'h3, 4'h3, 1'b1},
    {10'h001, 8'hF8, 4'h3, 4'h3, 1'b0},
    {10'h000, 8'hF9, 4'h3, 4'h3, 1'b0},
    {10'h000, 8'hF8, 4'h2, 4'h3, 1'b0},
    {10'h200, 8'hF8, 4'h5, 4'h5, 1'b0},
    {10'h000, 8'hF8, 4'hA, 4'hA, 1'b1},
    {10'h000, 8'h78, 4'h1, 4'h1, 1'b0},
    {10'h000, 8'hF8, 4'hF, 4'hF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_over(input int nbytes);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ pkt[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic build_pkt(input int seed);
    logic [15:0] c;
    for (int i = 0; i < 88; i++) pkt[i] = 8'((seed * 37 + i * 13 + (i >> 3)) ^ (seed << 4));
    c = crc_over(88);
    pkt[88] = c[15:8];
    pkt[89] = c[7:0];
  endtask

  // sends header then 90 bytes; R3 checked at the 89th/90th byte boundary
  task automatic send_pkt(input logic [9:0] a, input logic [7:0] t, input logic [3:0] g,
                          input bit chk_lock);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_addr = a; hdr_type = t; hdr_group = g;
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < 90; i++) begin
      in_valid = 1'b1; in_data = pkt[i];
      @(negedge clk);
      if (chk_lock && i == 88) check("R3 no lock after 89th byte", {31'd0, locked}, 32'd0);
    end
    in_valid = 1'b0;
    if (chk_lock) check("R3 lock after 90th byte", {31'd0, locked}, 32'd1);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) clear_req = 1'b1;
    else if (which == 1) rewind = 1'b1;
    else rd_strobe = 1'b1;
    @(negedge clk);
    clear_req = 1'b0; rewind = 1'b0; rd_strobe = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w0, syn0, exp_syn;
    int bad;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 locked", {31'd0, locked}, 32'd0);
    check("R11 eob", {31'd0, eob}, 32'd0);
    check("R11 rd_data", {16'd0, rd_data}, 32'd0);
    check("R11 syndrome", {16'd0, syndrome}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 in_ready high", {31'd0, in_ready}, 32'd1);

    // table walk: R1 / R2 filter, R10 zero syndrome, R6 first word
    for (int v = 0; v < 8; v++) begin
      sel_group = VEC[v][4:1];
      build_pkt(v + 1);
      send_pkt(VEC[v][26:17], VEC[v][16:9], VEC[v][8:5], 1'b0);
      check(VEC[v][0] ? "R1 capture" : "R2 reject", {31'd0, locked}, {31'd0, VEC[v][0]});
      if (VEC[v][0]) begin
        check("R6 first word", {16'd0, rd_data}, {16'd0, pkt[0], pkt[1]});
        check("R10 clean syndrome", {16'd0, syndrome}, 32'd0);
      end else begin
        check("R2 buffer untouched", {16'd0, rd_data}, 32'd0);
      end
      pulse(0);
    end

    // R5: stray bytes with no header are dropped
    build_pkt(20);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = pkt[i];
    end
    @(negedge clk); in_valid = 1'b0;
    check("R5 stray bytes dropped", {15'd0, locked, rd_data}, 32'd0);

    // full capture with R3 timing, then R6 readout
    sel_group = 4'h6;
    build_pkt(33);
    send_pkt(10'h000, 8'hF8, 4'h6, 1'b1);
    for (int i = 0; i < 90; i++) held[i] = pkt[i];
    bad = 0;
    for (int k = 0; k < 45; k++) begin
      if (rd_data !== {held[2*k], held[2*k+1]}) begin
        if (bad == 0) check("R6 word readout", {16'd0, rd_data}, {16'd0, held[2*k], held[2*k+1]});
        bad++;
      end
      pulse(2);
    end
    if (bad == 0) check("R6 word readout", 32'd0, 32'd0);
    // R7 past end
    check("R7 zero past end", {16'd0, rd_data}, 32'd0);
    check("R7 eob not yet", {31'd0, eob}, 32'd0);
    pulse(2);
    check("R7 eob set", {31'd0, eob}, 32'd1);
    pulse(2);
    check("R7 eob sticky", {15'd0, eob, rd_data}, {15'd0, 1'b1, 16'd0});
    // R8 rewind
    pulse(1);
    check("R8 eob cleared", {31'd0, eob}, 32'd0);
    check("R8 word0 again", {16'd0, rd_data}, {16'd0, held[0], held[1]});
    check("R8 still locked", {31'd0, locked}, 32'd1);

    // R4: matching packet while locked is ignored
    w0 = rd_data; syn0 = syndrome;
    build_pkt(44);
    pkt[89] = pkt[89] ^ 8'h01;
    send_pkt(10'h000, 8'hF8, 4'h6, 1'b0);
    check("R4 word unchanged", {16'd0, rd_data}, {16'd0, w0});
    check("R4 syndrome unchanged", {16'd0, syndrome}, {16'd0, syn0});
    repeat (20) @(negedge clk);
    check("R3 lock persists", {31'd0, locked}, 32'd1);

    // R9 clear
    pulse(0);
    check("R9 unlocked", {31'd0, locked}, 32'd0);
    check("R9 data zero", {16'd0, rd_data}, 32'd0);
    check("R9 syndrome zero", {16'd0, syndrome}, 32'd0);

    // R10 corrupted packet gives the bench-computed nonzero syndrome
    build_pkt(55);
    pkt[17] = pkt[17] ^ 8'h20;
    exp_syn = crc_over(90);
    send_pkt(10'h000, 8'hF8, 4'h6, 1'b0);
    check("R10 corrupt syndrome", {16'd0, syndrome}, {16'd0, exp_syn});
    check("R10 syndrome nonzero", {31'd0, (syndrome != 16'd0)}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule